// File: doc/BRIEF.md
# Flash Query-Mode Responder

This block answers reads while a parallel NOR flash sits in its standardized self-description mode (common flash interface query). It watches the command write bus of the flash, recognizes the command that opens query mode, and from then on returns, for each word read address, a byte describing the part: an identification string, the log2 of the device size, the count of populated erase regions and one four-byte descriptor per region. All of these values are derived at elaboration from per-region sector counts and sector sizes, so the same block serves uniform, top-boot and bottom-boot layouts.

Query mode may be entered from plain array-read mode or from the identification (autoselect) mode run by a neighbouring command decoder. The block records which of the two was active at entry. When the exit command arrives it leaves query mode and, if entry came from autoselect, raises a one-cycle hand-back pulse so the neighbour can resume autoselect instead of falling back to array read.

Top module: `cfi_query_resp`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, query_on and ret_autosel are 0 and rd_data is 0.
- R2: A write with cmd_we=1, cmd_data=0x98 and cmd_addr[7:0]=0x55, made while query_on is 0, sets query_on to 1 from the next clock edge; cmd_addr bits above bit 7 do not matter.
- R3: A write of 0x98 to a word address whose low byte is not 0x55, or of another value to 0x55, does not enter query mode; while query_on is 1, writes of any value other than 0xF0 leave the mode and the read data unchanged.
- R4: In query mode, rd_addr 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059 (ASCII Q, R, Y).
- R5: In query mode, rd_addr 0x27 reads the base-2 logarithm of the device size in bytes (sum over regions of count times size); an 8 MiB device reads 23.
- R6: In query mode, rd_addr 0x2C reads the number of regions whose sector count is nonzero.
- R7: In query mode, region r (0 to 3) occupies rd_addr 0x2D+4r to 0x30+4r: sector count minus one (low byte, then high byte), then sector size divided by 256 (low byte, then high byte); a region with a sector count of zero reads 0 at all four offsets.
- R8: In query mode every other rd_addr reads 0, bits 15:8 of rd_data are always 0, and outside query mode rd_data is 0.
- R9: A write with cmd_data=0xF0 at any address while query_on is 1 clears query_on from the next clock edge.
- R10: ret_autosel is 1 for exactly the one cycle after an exit per R9, and only if autosel_on was 1 at the clock edge that entered query mode; its level at exit time has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle per write |
| cmd_addr | input | ADDR_W | Word address of the command write |
| cmd_data | input | 8 | Command byte |
| autosel_on | input | 1 | Level from the command decoder: autoselect mode is active |
| rd_addr | input | ADDR_W | Word address being read |
| query_on | output | 1 | Query mode is active |
| ret_autosel | output | 1 | One-cycle pulse: resume autoselect after leaving query mode |
| rd_data | output | DATA_W | Query read data, low byte only |

## Verification
The assertions assume command writes are single-cycle strobes with stable address and data, and that autosel_on is a level sampled at the same edge as the entry write. The stimulus drives every input on the falling edge and holds cmd_we high for one cycle per command, so each write is seen at exactly one rising edge. A behavioural model tracks mode, entry origin and hand-back pulse, and computes every descriptor byte from its own copy of the geometry, which includes an empty region so the zero-count case is reached.

// File: rtl/cfi_query_resp.sv
module cfi_query_resp #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int unsigned RGN_CNT  [4] = '{127, 1, 2, 1},
  parameter int unsigned RGN_SIZE [4] = '{65536, 32768, 8192, 16384},
  parameter logic [7:0] QRY_CMD  = 8'h98,
  parameter logic [7:0] EXIT_CMD = 8'hF0,
  parameter logic [7:0] QRY_ADDR = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              autosel_on,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              query_on,
  output logic              ret_autosel,
  output logic [DATA_W-1:0] rd_data
);

  function automatic longint unsigned dev_bytes();
    longint unsigned s = 0;
    for (int r = 0; r < 4; r++) s += longint'(RGN_CNT[r]) * longint'(RGN_SIZE[r]);
    return s;
  endfunction

  function automatic int live_regions();
    int n = 0;
    for (int r = 0; r < 4; r++) if (RGN_CNT[r] != 0) n++;
    return n;
  endfunction

  localparam int DEV_LOG2 = $clog2(dev_bytes());
  localparam int N_LIVE   = live_regions();
  localparam int DESC_BASE = 'h2D;

  logic from_as;
  logic enter, leave;
  logic [7:0] byte_q;

  assign enter = cmd_we && !query_on && cmd_addr[7:0] == QRY_ADDR && cmd_data == QRY_CMD;
  assign leave = cmd_we && query_on && cmd_data == EXIT_CMD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      query_on    <= 1'b0;
      from_as     <= 1'b0;
      ret_autosel <= 1'b0;
    end else begin
      ret_autosel <= 1'b0;
      if (enter) begin
        query_on <= 1'b1;
        from_as  <= autosel_on;
      end else if (leave) begin
        query_on    <= 1'b0;
        ret_autosel <= from_as;
      end
    end
  end

  always_comb begin
    logic [31:0] cm1, unit;
    byte_q = 8'h00;
    cm1 = '0;
    unit = '0;
    case (rd_addr)
      ADDR_W'('h10): byte_q = 8'h51;
      ADDR_W'('h11): byte_q = 8'h52;
      ADDR_W'('h12): byte_q = 8'h59;
      ADDR_W'('h27): byte_q = 8'(DEV_LOG2);
      ADDR_W'('h2C): byte_q = 8'(N_LIVE);
      default: begin
        for (int r = 0; r < 4; r++) begin
          if (RGN_CNT[r] != 0) begin
            cm1  = RGN_CNT[r] - 1;
            unit = RGN_SIZE[r] >> 8;
            if (rd_addr == ADDR_W'(DESC_BASE + 4*r))     byte_q = cm1[7:0];
            if (rd_addr == ADDR_W'(DESC_BASE + 4*r + 1)) byte_q = cm1[15:8];
            if (rd_addr == ADDR_W'(DESC_BASE + 4*r + 2)) byte_q = unit[7:0];
            if (rd_addr == ADDR_W'(DESC_BASE + 4*r + 3)) byte_q = unit[15:8];
          end
        end
      end
    endcase
  end

  assign rd_data = query_on ? {{(DATA_W-8){1'b0}}, byte_q} : '0;

endmodule

module cfi_query_resp_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [7:0]        cmd_data,
  input logic              query_on,
  input logic              ret_autosel,
  input logic [DATA_W-1:0] rd_data
);

  AST_ENTER_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !query_on && cmd_addr[7:0] == 8'h55 && cmd_data == 8'h98) |=> query_on); // R2

  AST_STAY_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    (query_on && !(cmd_we && cmd_data == 8'hF0)) |=> query_on); // R3

  AST_NO_STRAY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!query_on && !(cmd_we && cmd_addr[7:0] == 8'h55 && cmd_data == 8'h98)) |=> !query_on); // R3

  AST_EXIT_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    (query_on && cmd_we && cmd_data == 8'hF0) |=> !query_on); // R9

  AST_HIGH_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:8] == '0); // R8

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !query_on |-> rd_data == '0); // R8

  AST_HANDBACK_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ret_autosel |-> (!query_on && $past(query_on))); // R10

  AST_HANDBACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_autosel |=> !ret_autosel); // R10

endmodule

bind cfi_query_resp cfi_query_resp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
  .query_on(query_on), .ret_autosel(ret_autosel), .rd_data(rd_data)
);

// File: tb/cfi_query_resp_test.sv
module cfi_query_resp_test;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int unsigned CNT [4] = '{2, 1, 127, 0};
  localparam int unsigned SZ  [4] = '{16384, 32768, 65536, 4096};

  logic clk = 0, rst_n = 0, cmd_we = 0, autosel_on = 0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic query_on, ret_autosel;
  logic [DW-1:0] rd_data;

  cfi_query_resp #(.ADDR_W(AW), .DATA_W(DW), .RGN_CNT(CNT), .RGN_SIZE(SZ)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .autosel_on(autosel_on), .rd_addr(rd_addr), .query_on(query_on),
    .ret_autosel(ret_autosel), .rd_data(rd_data));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit m_q = 0, m_from = 0, m_ret = 0, m_rst_seen = 0;

  // Reference model, updated at each rising edge from the values driven on the falling edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = 0; m_from = 0; m_ret = 0;
    end else begin
      m_ret = 0;
      if (cmd_we && !m_q && (cmd_addr % 256) == 'h55 && cmd_data == 'h98) begin
        m_q = 1; m_from = autosel_on;
      end else if (cmd_we && m_q && cmd_data == 'hF0) begin
        m_q = 0; m_ret = m_from;
      end
    end
  end

  function automatic int exp_byte(int a);
    longint total = 0;
    int n = 0, live = 0, r, k;
    if (!m_q) return 0;
    for (int i = 0; i < 4; i++) begin
      total += longint'(CNT[i]) * longint'(SZ[i]);
      if (CNT[i] > 0) live++;
    end
    if (a == 16) return 81;
    if (a == 17) return 82;
    if (a == 18) return 89;
    if (a == 39) begin
      while ((longint'(1) << n) < total) n++;
      return n;
    end
    if (a == 44) return live;
    if (a >= 45 && a < 61) begin
      r = (a - 45) / 4;
      k = (a - 45) % 4;
      if (CNT[r] == 0) return 0;
      case (k)
        0: return (CNT[r] - 1) % 256;
        1: return (CNT[r] - 1) / 256;
        2: return (SZ[r] / 256) % 256;
        default: return (SZ[r] / 256) / 256;
      endcase
    end
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (!m_q) return "R8";
    if (a >= 16 && a <= 18) return "R4";
    if (a == 39) return "R5";
    if (a == 44) return "R6";
    if (a >= 45 && a < 61) return "R7";
    return "R8";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Monitor: compares mid-high-phase, away from both edges
  always begin
    @(posedge clk);
    #5;
    if (!rst_n || !m_rst_seen) begin
      check("R1", "query_on in reset", int'(query_on), 0);
      check("R1", "ret_autosel in reset", int'(ret_autosel), 0);
      check("R1", "rd_data in reset", int'(rd_data), 0);
      if (rst_n) m_rst_seen = 1;
    end else begin
      check("R2 R3 R9", "query_on", int'(query_on), int'(m_q));
      check("R10", "ret_autosel", int'(ret_autosel), int'(m_ret));
      check(tag_of(int'(rd_addr)), $sformatf("rd_data@%0h", rd_addr), int'(rd_data),
            exp_byte(int'(rd_addr)));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cmd_we = 1; cmd_addr = AW'(a); cmd_data = 8'(d);
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic sweep(int lo, int hi);
    for (int a = lo; a <= hi; a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep(16, 18);                 // R8 outside query
    wr('h56, 'h98);                // R3 wrong address
    wr('h55, 'h90);                // R3 wrong value
    sweep(16, 18);
    wr('hA55, 'h98);               // R2 high bits ignored, from array read
    sweep(0, 'h45);                // R4 R5 R6 R7 R8
    wr('h55, 'h98);                // R3 repeat entry ignored
    wr('h555, 'hAA);               // R3 other value ignored
    sweep('h10, 'h12);
    wr('h123, 'hF0);               // R9 exit, R10 no hand-back
    sweep('h2C, 'h2E);
    @(negedge clk) autosel_on = 1;
    wr('h055, 'h98);               // R10 entry from autoselect
    @(negedge clk) autosel_on = 0; // level at exit must not matter
    sweep('h27, 'h3D);
    wr('h0, 'hF0);                 // R10 hand-back pulse expected
    repeat (3) @(negedge clk);
    wr('h055, 'h98);
    @(negedge clk) autosel_on = 1; // entry from array read, high at exit
    wr('h7FF, 'hF0);               // R10 no pulse
    repeat (2) @(negedge clk);
    autosel_on = 0;
    wr('h55, 'h98);
    sweep('h10, 'h11);
    @(negedge clk) rst_n = 0;      // R1 reset mid-query
    m_rst_seen = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    sweep('h10, 'h12);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule